// File: doc/BRIEF.md
# Bit-Addressed Control Latch Bank

This block sits on a serial, bit-addressed I/O bus of a video display terminal controller. It takes one data bit at a time and writes it into a latch inside one of four 8-latch banks. A word bit and a byte bit pick the bank. They are decoded into four active-low bank enables. A 3-bit bit address picks the latch inside that bank. A write happens only while the active-low strobe is low. Every latch that is not addressed keeps its value.

The four banks serve the controller as follows:
- Word 0 low byte holds the parallel write-data byte.
- Word 0 high byte holds the terminal control flags: test mode, cursor blink, keyboard interrupt enable, dual intensity and display enable.
- Word 1 low byte and word 1 high byte hold the 16-bit value presented to the cursor address register.

A separate command input is decoded into one-cycle load, increment and decrement requests for that cursor register.

Top module: `serial_latch_bank`

## Requirements
- R1: `bank_en_n` has exactly one bit low, at index {sel_word, sel_byte}:
  - 0 is word 0 low byte.
  - 1 is word 0 high byte.
  - 2 is word 1 low byte.
  - 3 is word 1 high byte.
- R2: Inside the selected bank, `bit_addr` picks latch `bit_addr` in binary order, so 000 is bit 0 and 111 is bit 7.
- R3: On a rising edge with `strobe_n` low, `ser_bit` is stored into the addressed latch of the selected bank only. With `strobe_n` high, no latch changes.
- R4: Bank 0 drives `wr_data[7:0]`. Successive writes to addresses 0 to 7 build a parallel byte.
- R5: Bank 1 drives `ctrl_q[7:0]`. The named active-high controls come from these bits:
  - `test_mode` is bit 1.
  - `blink_en` is bit 3. A 0 in this bit disables cursor blinking.
  - `kbd_irq_en` is bit 4.
  - `dual_int_en` is bit 5.
  - `disp_en` is bit 6.
- R6: Bank 2 drives `cursor_addr[7:0]` and bank 3 drives `cursor_addr[15:8]`.
- R7: A write is visible on the outputs right after the edge that samples the strobe. Holding the strobe for several cycles only rewrites the same latch.
- R8: When `cmd_valid` is high at a rising edge, `cmd_op` is decoded and the result is presented for the following cycle:
  - 01 raises `cur_load`.
  - 10 raises `cur_inc`.
  - 11 raises `cur_dec`.
  - 00 raises nothing.
  
  When `cmd_valid` is low, all three outputs are low. At most one of the three is ever high.
- R9: A synchronous active-high `rst` clears every latch and all three command outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sel_word | input | 1 | Word select |
| sel_byte | input | 1 | Byte select |
| bit_addr | input | 3 | Latch address within bank |
| ser_bit | input | 1 | Serial data bit |
| strobe_n | input | 1 | Write strobe, active low |
| cmd_valid | input | 1 | Cursor command present |
| cmd_op | input | 2 | Cursor command code |
| bank_en_n | output | 4 | Decoded bank enables, active low |
| wr_data | output | 8 | Write-data bank |
| ctrl_q | output | 8 | Control bank |
| test_mode | output | 1 | Test mode select |
| blink_en | output | 1 | Cursor blink enable |
| kbd_irq_en | output | 1 | Keyboard interrupt enable |
| dual_int_en | output | 1 | Dual intensity enable |
| disp_en | output | 1 | Display enable |
| cursor_addr | output | 16 | Cursor address latches |
| cur_load | output | 1 | Cursor load request |
| cur_inc | output | 1 | Cursor increment request |
| cur_dec | output | 1 | Cursor decrement request |

## Verification
All 32 latches appear directly on the outputs, so a corrupted latch shows up within one cycle of the write that caused it.

A write that lands in the wrong bank or at the wrong bit disturbs one or two output bits. Every write is compared against a bench model on the next falling edge, which exposes it at once.

A command decoding fault shows on the three request outputs in the cycle right after the command is sampled.

A reset that leaves any state behind shows at the first check after reset.

// File: rtl/serial_latch_bank.sv
module serial_latch_bank #(
  parameter int BANK_W = 8,
  parameter int N_BANK = 4,
  parameter int TEST_BIT  = 1,
  parameter int BLINK_BIT = 3,
  parameter int KBD_BIT   = 4,
  parameter int DUAL_BIT  = 5,
  parameter int DISP_BIT  = 6
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        sel_word,
  input  logic        sel_byte,
  input  logic [2:0]  bit_addr,
  input  logic        ser_bit,
  input  logic        strobe_n,
  input  logic        cmd_valid,
  input  logic [1:0]  cmd_op,
  output logic [3:0]  bank_en_n,
  output logic [7:0]  wr_data,
  output logic [7:0]  ctrl_q,
  output logic        test_mode,
  output logic        blink_en,
  output logic        kbd_irq_en,
  output logic        dual_int_en,
  output logic        disp_en,
  output logic [15:0] cursor_addr,
  output logic        cur_load,
  output logic        cur_inc,
  output logic        cur_dec
);
  localparam int SEL_W = $clog2(N_BANK);

  logic [SEL_W-1:0]              bank_idx;
  logic [N_BANK-1:0][BANK_W-1:0] latch_q;

  assign bank_idx  = {sel_word, sel_byte};
  assign bank_en_n = ~(N_BANK'(1) << bank_idx);

  for (genvar b = 0; b < N_BANK; b++) begin : g_bank
    for (genvar i = 0; i < BANK_W; i++) begin : g_bit
      always_ff @(posedge clk) begin
        if (rst)
          latch_q[b][i] <= 1'b0;
        else if (!strobe_n && !bank_en_n[b] && bit_addr == 3'(i))
          latch_q[b][i] <= ser_bit;
      end
    end
  end

  assign wr_data     = latch_q[0];
  assign ctrl_q      = latch_q[1];
  assign cursor_addr = {latch_q[3], latch_q[2]};

  assign test_mode   = ctrl_q[TEST_BIT];
  assign blink_en    = ctrl_q[BLINK_BIT];
  assign kbd_irq_en  = ctrl_q[KBD_BIT];
  assign dual_int_en = ctrl_q[DUAL_BIT];
  assign disp_en     = ctrl_q[DISP_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_load <= 1'b0;
      cur_inc  <= 1'b0;
      cur_dec  <= 1'b0;
    end else begin
      cur_load <= cmd_valid && cmd_op == 2'b01;
      cur_inc  <= cmd_valid && cmd_op == 2'b10;
      cur_dec  <= cmd_valid && cmd_op == 2'b11;
    end
  end
endmodule

// File: rtl/serial_latch_bank_chk.sv
module serial_latch_bank_chk (
  input logic        clk,
  input logic        rst,
  input logic        sel_word,
  input logic        sel_byte,
  input logic [2:0]  bit_addr,
  input logic        ser_bit,
  input logic        strobe_n,
  input logic        cmd_valid,
  input logic [1:0]  cmd_op,
  input logic [3:0]  bank_en_n,
  input logic [7:0]  wr_data,
  input logic [7:0]  ctrl_q,
  input logic [15:0] cursor_addr,
  input logic        cur_load,
  input logic        cur_inc,
  input logic        cur_dec
);
  logic [31:0] all_q;
  logic [4:0]  wr_idx;
  assign all_q  = {cursor_addr, ctrl_q, wr_data};
  assign wr_idx = {sel_word, sel_byte, bit_addr};

  AST_ONE_ENABLE: assert property (@(posedge clk) disable iff (rst)
    $countones(~bank_en_n) == 1 && !bank_en_n[{sel_word, sel_byte}]); // R1
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    !strobe_n |=> all_q[$past(wr_idx)] == $past(ser_bit)); // R2
  AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (rst)
    !strobe_n |=> $countones(all_q ^ $past(all_q)) <= 1); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    strobe_n |=> $stable(all_q)); // R3
  AST_CMD_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cur_load, cur_inc, cur_dec})); // R8
  AST_CMD_DECODE: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_op == 2'b11 |=> cur_dec); // R8
  AST_CMD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |=> !(cur_load || cur_inc || cur_dec)); // R8
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> all_q == 32'd0 && !(cur_load || cur_inc || cur_dec)); // R9
endmodule

bind serial_latch_bank serial_latch_bank_chk u_chk (.*);

// File: tb/serial_latch_bank_bench.sv
module serial_latch_bank_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sel_word = 0, sel_byte = 0, ser_bit = 0, strobe_n = 1, cmd_valid = 0;
  logic [2:0] bit_addr = 0;
  logic [1:0] cmd_op = 0;
  logic [3:0] bank_en_n;
  logic [7:0] wr_data, ctrl_q;
  logic test_mode, blink_en, kbd_irq_en, dual_int_en, disp_en;
  logic [15:0] cursor_addr;
  logic cur_load, cur_inc, cur_dec;

  int checks = 0, errors = 0;
  logic [31:0] m_q = 0;
  logic [2:0]  m_cmd = 0;

  always #2 clk = ~clk;

  serial_latch_bank u_serial_latch_bank (.*);

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: act=hung exp=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  function automatic logic [3:0] exp_en(logic w, logic b);
    return ~(4'b1 << {w, b});
  endfunction

  function automatic logic [2:0] exp_cmd(logic v, logic [1:0] op);
    if (!v) return 3'b000;
    case (op)
      2'b01: return 3'b100;
      2'b10: return 3'b010;
      2'b11: return 3'b001;
      default: return 3'b000;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic check_all(string req);
    chk(req, {cursor_addr, ctrl_q, wr_data}, m_q);
    chk("R5 named controls", {27'd0, test_mode, blink_en, kbd_irq_en, dual_int_en, disp_en},
        {27'd0, m_q[9], m_q[11], m_q[12], m_q[13], m_q[14]});
    chk("R8 cmd", {29'd0, cur_load, cur_inc, cur_dec}, {29'd0, m_cmd});
  endtask

  task automatic cyc(string req);
    @(posedge clk);
    if (rst) begin
      m_q = 0;
      m_cmd = 0;
    end else begin
      if (!strobe_n) m_q[{sel_word, sel_byte, bit_addr}] = ser_bit;
      m_cmd = exp_cmd(cmd_valid, cmd_op);
    end
    @(negedge clk);
    check_all(req);
  endtask

  task automatic wr(logic w, logic b, logic [2:0] a, logic d, string req);
    sel_word = w; sel_byte = b; bit_addr = a; ser_bit = d; strobe_n = 0;
    cyc(req);
    strobe_n = 1;
  endtask

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    cyc("R9 reset");
    cyc("R9 reset");
    rst = 0;
    chk("R9 reset state", {cursor_addr, ctrl_q, wr_data}, 32'd0);

    for (int k = 0; k < 4; k++) begin
      sel_word = k[1]; sel_byte = k[0]; #1;
      chk("R1 enable decode", {28'd0, bank_en_n}, {28'd0, exp_en(k[1], k[0])});
    end

    for (int i = 0; i < 8; i++) wr(0, 0, 3'(i), ((8'hA5 >> i) & 1) != 0, "R4 byte build");
    chk("R4 wr_data", {24'd0, wr_data}, 32'hA5);
    wr(0, 0, 3'd7, 0, "R2 top bit");
    chk("R2 addr 111 is bit 7", {24'd0, wr_data}, 32'h25);

    wr(0, 1, 3'd6, 1, "R5 display");
    wr(0, 1, 3'd3, 1, "R5 blink");
    chk("R5 disp_en", {31'd0, disp_en}, 1);
    chk("R5 blink_en", {31'd0, blink_en}, 1);
    wr(0, 1, 3'd3, 0, "R5 blink off");
    chk("R5 blink disabled by 0", {31'd0, blink_en}, 0);

    wr(1, 0, 3'd0, 1, "R6 cursor low");
    wr(1, 1, 3'd7, 1, "R6 cursor high");
    chk("R6 cursor_addr", {16'd0, cursor_addr}, 32'h8001);

    sel_word = 0; sel_byte = 0; bit_addr = 3'd2; ser_bit = 1; strobe_n = 0;
    for (int i = 0; i < 4; i++) cyc("R7 held strobe");
    strobe_n = 1;
    ser_bit = 0;
    cyc("R3 strobe high ignores data");

    for (int op = 0; op < 4; op++) begin
      cmd_valid = 1; cmd_op = 2'(op);
      cyc("R8 cmd decode");
    end
    cmd_valid = 0; cmd_op = 2'b10;
    cyc("R8 invalid cmd");

    for (int n = 0; n < 3000; n++) begin
      rst       = ($urandom % 64) == 0;
      sel_word  = 1'($urandom);
      sel_byte  = 1'($urandom);
      bit_addr  = 3'($urandom);
      ser_bit   = 1'($urandom);
      strobe_n  = 1'($urandom);
      cmd_valid = 1'($urandom);
      cmd_op    = 2'($urandom);
      #1;
      chk("R1 random enable", {28'd0, bank_en_n}, {28'd0, exp_en(sel_word, sel_byte)});
      cyc("R3 random");
    end
    rst = 1;
    cyc("R9 final reset");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule